// File: doc/BRIEF.md
# Instruction Prefetch Bus Interface

This block reads instruction bytes ahead of the execution side and keeps them in a six-byte first-in first-out queue. The execution side takes one byte per cycle from the head of the queue. Fetching goes on in the same cycles, so decode does not wait on memory while the queue holds bytes. Each fetch address is built from a 16-bit code segment value and a 16-bit fetch offset. The segment is shifted up by four bit positions and the offset is added to it, which gives a 20-bit physical address.

The memory side is a request/ready handshake on a data bus. A parameter sets the bus to 8 or 16 bits. With the byte-wide bus every access brings in one byte, so a 16-bit word costs two accesses. With the word-wide bus an even offset brings in two bytes in one access. An odd offset first costs a single-byte access, and after that the accesses are word-aligned. A jump is handled by a flush command that carries the new offset. The flush empties the queue in one cycle, abandons any access still pending and starts fetching again from the new target.

Top module: `prefetch_biu`

## Requirements
- R1: Bytes leave the queue in ascending fetch-address order. The byte at `q_byte_o` is the oldest one held. The queue never holds more than 6 bytes.
- R2: The physical address is (`cseg_i` × 16 + fetch offset) taken modulo 2^20. For example, 2500h:95F3h gives 2E5F3h, 2567h:2341h gives 279B1h, and FFFFh:0010h wraps to 00000h.
- R3: A take and an incoming transfer in the same cycle both take effect. `q_count_o` then changes by the number of bytes loaded minus the number of bytes taken.
- R4: With an 8-bit bus (`BUS_W`=8), `mem_wide_o` stays low and every access loads one byte from `mem_rdata_i[7:0]`. A two-byte word therefore costs two accesses.
- R5: With a 16-bit bus, an access at an even offset is wide (`mem_wide_o`=1). It loads bits [7:0] first and bits [15:8] second. An access at an odd offset is narrow (`mem_wide_o`=0) and loads bits [15:8] only.
- R6: A new access starts only when the queue has room for a whole transfer: 2 free bytes for a wide access and 1 for a narrow one. With the 16-bit bus and an odd start offset, the queue therefore stops filling at 5 bytes.
- R7: `flush_i` empties the queue and drops `mem_req_o` at the next clock edge. A response that arrives in that cycle or later for the abandoned access is discarded. Fetching restarts one cycle later at `flush_off_i`.
- R8: `take_i` has no effect while `q_empty_o` is high. `q_empty_o` stays high until a transfer is loaded.
- R9: The fetch offset advances by the number of bytes loaded and wraps within 16 bits.
- R10: After reset the queue is empty and `mem_req_o` is low. Fetching begins at the first clock edge after reset is released, at offset `RESET_OFF` (default 0).
- R11: `mem_req_o` stays high, with a steady address, until `mem_rdy_i` completes the access. `mem_rdy_i` is ignored while no access is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cseg_i | input | 16 | Code segment value |
| flush_i | input | 1 | Discard queue and restart at a new offset |
| flush_off_i | input | 16 | New fetch offset used with `flush_i` |
| take_i | input | 1 | Execution side takes the head byte |
| q_byte_o | output | 8 | Head byte of the queue |
| q_empty_o | output | 1 | Queue holds no bytes |
| q_count_o | output | 3 | Number of bytes held |
| mem_req_o | output | 1 | Memory read request |
| mem_wide_o | output | 1 | Request is a two-byte access |
| mem_addr_o | output | 20 | Physical read address |
| mem_rdy_i | input | 1 | Read completes this cycle, data valid |
| mem_rdata_i | input | BUS_W | Read data, even byte in bits [7:0] |

## Verification
The properties make three assumptions about the memory and segment inputs:
- `cseg_i` is held constant while an access is pending, unless a flush arrives in that same cycle.
- The memory raises `mem_rdy_i` for one cycle per access and returns data that belongs to the address being requested.
- A ready pulse that lags a flush can reach the block while no access is pending, and it must be ignored.

The bench memory model follows these assumptions. It counts its latency only while a request is high, sends a single pulse per access, and can be stalled indefinitely. The bench changes the segment only in the same cycle as a flush. `take_i` is unconstrained: the bench raises it even on an empty queue.

// File: rtl/pfq_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the prefetch unit.
// Assumes instruction bytes are 8 bits wide.
package pfq_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;
    typedef enum logic {ACC_NARROW = 1'b0, ACC_WIDE = 1'b1} acc_size_e;
endpackage

// File: rtl/pfq_addr_gen.sv
`timescale 1ns/1ps
// Forms the physical fetch address from segment and offset.
// Assumes SEG_W + SHIFT == ADDR_W; the sum wraps modulo 2^ADDR_W.
module pfq_addr_gen #(
    parameter int SEG_W  = 16,
    parameter int OFF_W  = 16,
    parameter int SHIFT  = 4,
    parameter int ADDR_W = 20
) (
    input  logic [SEG_W-1:0]  seg_i,
    input  logic [OFF_W-1:0]  off_i,
    output logic [ADDR_W-1:0] addr_o
);
    logic [ADDR_W-1:0] seg_shifted;
    logic [ADDR_W-1:0] off_ext;

    // Shift the segment up and add the offset; the adder drops its carry.
    always_comb begin
        seg_shifted = ADDR_W'({seg_i, {SHIFT{1'b0}}});
        off_ext     = ADDR_W'(off_i);
        addr_o      = seg_shifted + off_ext;
    end
endmodule

// File: rtl/pfq_byte_fifo.sv
`timescale 1ns/1ps
// Circular byte queue with up to two writes and one read per cycle.
// Assumes the writer never pushes more bytes than there are free slots.
module pfq_byte_fifo
    import pfq_pkg::*;
#(
    parameter int DEPTH = 6,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic [1:0]       push_n_i,
    input  byte_t            push_b0_i,
    input  byte_t            push_b1_i,
    input  logic             pop_i,
    output byte_t            head_o,
    output logic [CNT_W-1:0] count_o,
    output logic             empty_o
);
    localparam int PTR_W = $clog2(DEPTH);

    byte_t            store_q [DEPTH];
    logic [PTR_W-1:0] rd_q, wr_q, wr_nxt1;
    logic [CNT_W-1:0] count_q;
    logic             pop_ok;

    function automatic logic [PTR_W-1:0] ptr_add(input logic [PTR_W-1:0] p, input int k);
        int s;
        s = int'(p) + k;
        if (s >= DEPTH) s = s - DEPTH;
        return PTR_W'(s);
    endfunction

    // A read only counts when a byte is actually held.
    always_comb begin
        pop_ok  = pop_i && (count_q != '0);
        wr_nxt1 = ptr_add(wr_q, 1);
        head_o  = store_q[rd_q];
        count_o = count_q;
        empty_o = (count_q == '0);
    end

    // Write incoming bytes into the slots at the write pointer.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!clr_i && push_n_i != 2'd0 && PTR_W'(i) == wr_q)
                store_q[i] <= push_b0_i;
            else if (!clr_i && push_n_i == 2'd2 && PTR_W'(i) == wr_nxt1)
                store_q[i] <= push_b1_i;
        end
    end

    // Move the pointers and the fill count; clear wins over everything.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            rd_q    <= '0;
            wr_q    <= '0;
            count_q <= '0;
        end else begin
            if (pop_ok) rd_q <= ptr_add(rd_q, 1);
            wr_q    <= ptr_add(wr_q, int'(push_n_i));
            count_q <= count_q + CNT_W'(push_n_i) - CNT_W'(pop_ok);
        end
    end
endmodule

// File: rtl/pfq_fetch_ctl.sv
`timescale 1ns/1ps
// Fetch sequencer: keeps the fetch offset, decides when and how wide to read,
// and picks byte lanes from the returned data.
// Assumes memory answers with a single ready pulse and only while a request is up.
module pfq_fetch_ctl
    import pfq_pkg::*;
#(
    parameter int             BUS_W     = 16,
    parameter int             Q_DEPTH   = 6,
    parameter int             OFF_W     = 16,
    parameter int             CNT_W     = $clog2(Q_DEPTH + 1),
    parameter logic [OFF_W-1:0] RESET_OFF = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic [OFF_W-1:0] flush_off_i,
    input  logic [CNT_W-1:0] q_count_i,
    input  logic             mem_rdy_i,
    input  logic [BUS_W-1:0] mem_rdata_i,
    output logic             req_o,
    output logic             wide_o,
    output logic [OFF_W-1:0] off_o,
    output logic [1:0]       push_n_o,
    output byte_t            push_b0_o,
    output byte_t            push_b1_o
);
    localparam bit WIDE_BUS = (BUS_W == 16);

    logic             busy_q;
    acc_size_e        size_q, size_nxt;
    logic [OFF_W-1:0] off_q;
    logic [CNT_W:0]   need, fill_after;
    logic             room, start, accept;

    // Choose the next access size and test whether the queue can take it.
    always_comb begin
        size_nxt   = (WIDE_BUS && !off_q[0]) ? ACC_WIDE : ACC_NARROW;
        need       = (size_nxt == ACC_WIDE) ? (CNT_W+1)'(2) : (CNT_W+1)'(1);
        fill_after = {1'b0, q_count_i} + need;
        room       = fill_after <= (CNT_W+1)'(Q_DEPTH);
        start      = !busy_q && !flush_i && room;
        accept     = busy_q && mem_rdy_i && !flush_i;
        push_n_o   = !accept ? 2'd0 : (size_q == ACC_WIDE) ? 2'd2 : 2'd1;
        req_o      = busy_q;
        wide_o     = busy_q && (size_q == ACC_WIDE);
        off_o      = off_q;
    end

    // Lane selection depends on the bus width.
    generate
        if (WIDE_BUS) begin : g_word_bus
            always_comb begin
                push_b0_o = off_q[0] ? mem_rdata_i[15:8] : mem_rdata_i[7:0];
                push_b1_o = mem_rdata_i[15:8];
            end
        end else begin : g_byte_bus
            always_comb begin
                push_b0_o = mem_rdata_i[7:0];
                push_b1_o = '0;
            end
        end
    endgenerate

    // Track the pending access and advance the offset by the bytes loaded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            size_q <= ACC_NARROW;
            off_q  <= RESET_OFF;
        end else if (flush_i) begin
            busy_q <= 1'b0;
            off_q  <= flush_off_i;
        end else if (accept) begin
            busy_q <= 1'b0;
            off_q  <= off_q + OFF_W'(push_n_o);
        end else if (start) begin
            busy_q <= 1'b1;
            size_q <= size_nxt;
        end
    end
endmodule

// File: rtl/prefetch_biu.sv
`timescale 1ns/1ps
// Instruction prefetch unit: fetches code bytes ahead of use into a byte queue.
// Assumes cseg_i stays constant while an access is pending unless flushed.
module prefetch_biu
    import pfq_pkg::*;
#(
    parameter int             BUS_W     = 16,
    parameter int             Q_DEPTH   = 6,
    parameter int             SEG_W     = 16,
    parameter int             OFF_W     = 16,
    parameter int             SHIFT     = 4,
    parameter int             ADDR_W    = 20,
    parameter logic [OFF_W-1:0] RESET_OFF = '0,
    localparam int            CNT_W     = $clog2(Q_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEG_W-1:0]  cseg_i,
    input  logic              flush_i,
    input  logic [OFF_W-1:0]  flush_off_i,
    input  logic              take_i,
    output logic [7:0]        q_byte_o,
    output logic              q_empty_o,
    output logic [CNT_W-1:0]  q_count_o,
    output logic              mem_req_o,
    output logic              mem_wide_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic              mem_rdy_i,
    input  logic [BUS_W-1:0]  mem_rdata_i
);
    logic [OFF_W-1:0] fetch_off;
    logic [1:0]       push_n;
    byte_t            push_b0, push_b1;

    pfq_fetch_ctl #(
        .BUS_W(BUS_W), .Q_DEPTH(Q_DEPTH), .OFF_W(OFF_W),
        .CNT_W(CNT_W), .RESET_OFF(RESET_OFF)
    ) ctl_i (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .flush_off_i(flush_off_i),
        .q_count_i(q_count_o), .mem_rdy_i(mem_rdy_i), .mem_rdata_i(mem_rdata_i),
        .req_o(mem_req_o), .wide_o(mem_wide_o), .off_o(fetch_off),
        .push_n_o(push_n), .push_b0_o(push_b0), .push_b1_o(push_b1)
    );

    pfq_addr_gen #(
        .SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .ADDR_W(ADDR_W)
    ) agen_i (
        .seg_i(cseg_i), .off_i(fetch_off), .addr_o(mem_addr_o)
    );

    pfq_byte_fifo #(
        .DEPTH(Q_DEPTH), .CNT_W(CNT_W)
    ) fifo_i (
        .clk(clk), .rst_n(rst_n), .clr_i(flush_i), .push_n_i(push_n),
        .push_b0_i(push_b0), .push_b1_i(push_b1), .pop_i(take_i),
        .head_o(q_byte_o), .count_o(q_count_o), .empty_o(q_empty_o)
    );
endmodule

// File: rtl/pfq_checker.sv
`timescale 1ns/1ps
// Property checker for the prefetch unit, attached by bind below.
// Assumes the memory and segment input rules listed in the brief.
module pfq_checker #(
    parameter int BUS_W   = 16,
    parameter int Q_DEPTH = 6,
    parameter int CNT_W   = 3,
    parameter int SEG_W   = 16,
    parameter int ADDR_W  = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic [SEG_W-1:0]  cseg_i,
    input logic              flush_i,
    input logic              q_empty_o,
    input logic [CNT_W-1:0]  q_count_o,
    input logic              mem_req_o,
    input logic              mem_wide_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              mem_rdy_i
);
    // R1: never more bytes than slots
    a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        int'(q_count_o) <= Q_DEPTH);

    // R6: a request only rises when the whole transfer fits
    a_r6_room_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req_o) |-> (int'(q_count_o) + (mem_wide_o ? 2 : 1)) <= Q_DEPTH);

    // R7: flush empties the queue and drops the request
    a_r7_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (q_empty_o && q_count_o == '0 && !mem_req_o));

    // R8: an empty queue stays empty without a completed transfer
    a_r8_empty_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (q_empty_o && !(mem_req_o && mem_rdy_i)) |=> q_empty_o);

    // R5: wide accesses are word aligned
    a_r5_wide_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_wide_o) |-> !mem_addr_o[0]);

    // R5: odd addresses use single-byte accesses
    a_r5_odd_narrow: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_addr_o[0]) |-> !mem_wide_o);

    // R11: request held until completion
    a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_rdy_i && !flush_i) |=> mem_req_o);

    // R11: address steady while pending and segment steady
    a_r11_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_rdy_i && !flush_i) ##1 $stable(cseg_i) |-> $stable(mem_addr_o));

    generate
        if (BUS_W == 8) begin : g_byte_bus
            // R4: byte bus never asks for two bytes
            a_r4_byte_only: assert property (@(posedge clk) disable iff (!rst_n)
                mem_req_o |-> !mem_wide_o);
        end
    endgenerate
endmodule

bind prefetch_biu pfq_checker #(
    .BUS_W(BUS_W), .Q_DEPTH(Q_DEPTH), .CNT_W(CNT_W), .SEG_W(SEG_W), .ADDR_W(ADDR_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .cseg_i(cseg_i), .flush_i(flush_i),
    .q_empty_o(q_empty_o), .q_count_o(q_count_o), .mem_req_o(mem_req_o),
    .mem_wide_o(mem_wide_o), .mem_addr_o(mem_addr_o), .mem_rdy_i(mem_rdy_i)
);

// File: tb/prefetch_biu_tb_top.sv
`timescale 1ns/1ps
module prefetch_biu_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cseg = 16'h0040;
    logic        flush = 1'b0;
    logic [15:0] foff = 16'h0000;
    logic        take16 = 1'b0, take8 = 1'b0;
    logic        stall = 1'b0;
    int          lat = 1;

    logic [7:0]  q16_byte, q8_byte;
    logic        q16_empty, q8_empty, req16, req8, wide16, wide8;
    logic [2:0]  q16_cnt, q8_cnt;
    logic [19:0] addr16, addr8;
    logic        rdy16, rdy8;
    logic [15:0] rdata16;
    logic [7:0]  rdata8;
    int          cnt16, cnt8, acc16, acc8;

    int tests = 0, fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    prefetch_biu #(.BUS_W(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .cseg_i(cseg), .flush_i(flush), .flush_off_i(foff),
        .take_i(take16), .q_byte_o(q16_byte), .q_empty_o(q16_empty), .q_count_o(q16_cnt),
        .mem_req_o(req16), .mem_wide_o(wide16), .mem_addr_o(addr16),
        .mem_rdy_i(rdy16), .mem_rdata_i(rdata16));

    prefetch_biu #(.BUS_W(8)) dut_b8_i (
        .clk(clk), .rst_n(rst_n), .cseg_i(cseg), .flush_i(flush), .flush_off_i(foff),
        .take_i(take8), .q_byte_o(q8_byte), .q_empty_o(q8_empty), .q_count_o(q8_cnt),
        .mem_req_o(req8), .mem_wide_o(wide8), .mem_addr_o(addr8),
        .mem_rdy_i(rdy8), .mem_rdata_i(rdata8));

    function automatic logic [7:0] fb(input logic [19:0] a);
        return a[7:0] ^ a[15:8] ^ {a[11:8], a[19:16]};
    endfunction
    function automatic logic [19:0] pa(input logic [15:0] s, input logic [15:0] o);
        return 20'({s, 4'h0}) + 20'(o);
    endfunction
    function automatic logic [7:0] xb(input logic [15:0] s, input logic [15:0] o, input int i);
        return fb(pa(s, o + 16'(i)));
    endfunction

    // Memory models: latency counted while a request is up, one ready pulse.
    always @(posedge clk) begin
        if (!rst_n) begin
            rdy16 <= 1'b0; cnt16 <= 0; acc16 <= 0;
        end else if (rdy16) begin
            rdy16 <= 1'b0; cnt16 <= 0;
        end else if (req16 && !stall) begin
            if (cnt16 >= lat) begin
                rdy16   <= 1'b1;
                rdata16 <= {fb({addr16[19:1], 1'b1}), fb({addr16[19:1], 1'b0})};
                acc16   <= acc16 + 1;
            end else cnt16 <= cnt16 + 1;
        end else cnt16 <= 0;
    end
    always @(posedge clk) begin
        if (!rst_n) begin
            rdy8 <= 1'b0; cnt8 <= 0; acc8 <= 0;
        end else if (rdy8) begin
            rdy8 <= 1'b0; cnt8 <= 0;
        end else if (req8 && !stall) begin
            if (cnt8 >= lat) begin
                rdy8   <= 1'b1;
                rdata8 <= fb(addr8);
                acc8   <= acc8 + 1;
            end else cnt8 <= cnt8 + 1;
        end else cnt8 <= 0;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_flush(input logic [15:0] s, input logic [15:0] o);
        @(negedge clk);
        cseg = s; foff = o; flush = 1'b1; take16 = 1'b0; take8 = 1'b0;
        @(negedge clk);
        flush = 1'b0;
    endtask

    // Take n bytes from both units, checking data and the per-cycle fill count.
    task automatic consume(input logic [15:0] s, input logic [15:0] o, input int n, input string tag);
        int i16 = 0, i8 = 0, guard = 0, ec16 = 0, ec8 = 0;
        bit have = 1'b0;
        while ((i16 < n || i8 < n) && guard < 3000) begin
            @(negedge clk);
            guard++;
            if (have) begin
                chk(int'(q16_cnt) == ec16, "R3 count16", 32'(q16_cnt), 32'(ec16));
                chk(int'(q8_cnt) == ec8, "R3 count8", 32'(q8_cnt), 32'(ec8));
            end
            ec16 = int'(q16_cnt) + ((req16 && rdy16) ? (wide16 ? 2 : 1) : 0)
                   - ((i16 < n && !q16_empty) ? 1 : 0);
            ec8  = int'(q8_cnt) + ((req8 && rdy8) ? 1 : 0)
                   - ((i8 < n && !q8_empty) ? 1 : 0);
            if (i16 < n && !q16_empty) begin
                chk(q16_byte == xb(s, o, i16), {tag, " bus16"}, 32'(q16_byte), 32'(xb(s, o, i16)));
                take16 = 1'b1; i16++;
            end else take16 = 1'b0;
            if (i8 < n && !q8_empty) begin
                chk(q8_byte == xb(s, o, i8), {tag, " bus8"}, 32'(q8_byte), 32'(xb(s, o, i8)));
                take8 = 1'b1; i8++;
            end else take8 = 1'b0;
            have = 1'b1;
        end
        @(negedge clk);
        chk(int'(q16_cnt) == ec16, "R3 count16", 32'(q16_cnt), 32'(ec16));
        chk(int'(q8_cnt) == ec8, "R3 count8", 32'(q8_cnt), 32'(ec8));
        take16 = 1'b0; take8 = 1'b0;
        chk(guard < 3000, "R1 stream stalled", 32'(i16 + i8), 32'(2 * n));
    endtask

    typedef struct packed {
        logic [15:0] seg;
        logic [15:0] off;
        logic [7:0]  n;
        logic [3:0]  lat;
        logic [19:0] pa;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{16'h2500, 16'h95F3, 8'd10, 4'd1, 20'h2E5F3},
        '{16'h2567, 16'h2341, 8'd9,  4'd0, 20'h279B1},
        '{16'hFFFF, 16'h0010, 8'd8,  4'd2, 20'h00000},
        '{16'h1000, 16'hFFFE, 8'd7,  4'd1, 20'h1FFFE},
        '{16'h1000, 16'hFFFF, 8'd5,  4'd3, 20'h1FFFF},
        '{16'h0ABC, 16'h0001, 8'd12, 4'd0, 20'h0ABC1}
    };

    initial begin
        #(64'd20 * 64'd190000);
        if (!done) begin
            tests++; fails++;
            $display("FAIL R1 watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int s16, s8;
        // R10: reset state
        repeat (4) @(negedge clk);
        chk(q16_empty && q8_empty, "R10 empty in reset", 32'({q16_empty, q8_empty}), 32'h3);
        chk(q16_cnt == 3'd0 && q8_cnt == 3'd0, "R10 count in reset", 32'({q16_cnt, q8_cnt}), 32'h0);
        chk(!req16 && !req8, "R10 no request in reset", 32'({req16, req8}), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req16 && addr16 == 20'h00400, "R10 first fetch bus16", 32'(addr16), 32'h00400);
        chk(req8 && addr8 == 20'h00400, "R10 first fetch bus8", 32'(addr8), 32'h00400);

        // Vector table: address formation, access size, stream order, offset wrap
        for (int k = 0; k < 6; k++) begin
            lat = int'(VECS[k].lat);
            do_flush(VECS[k].seg, VECS[k].off);
            @(negedge clk);
            chk(req16 && addr16 == VECS[k].pa, "R2 address bus16", 32'(addr16), 32'(VECS[k].pa));
            chk(req8 && addr8 == VECS[k].pa, "R2 address bus8", 32'(addr8), 32'(VECS[k].pa));
            chk(wide16 == !VECS[k].off[0], "R5 access size", 32'(wide16), 32'(!VECS[k].off[0]));
            chk(!wide8, "R4 byte access", 32'(wide8), 32'h0);
            consume(VECS[k].seg, VECS[k].off, int'(VECS[k].n), "R1 R9 data");
        end

        // R6 and R4/R5: fill from even offset, count accesses
        lat = 1;
        do_flush(16'h3000, 16'h0100);
        s16 = acc16; s8 = acc8;
        repeat (40) @(negedge clk);
        chk(q16_cnt == 3'd6, "R6 full bus16", 32'(q16_cnt), 32'd6);
        chk(q8_cnt == 3'd6, "R6 full bus8", 32'(q8_cnt), 32'd6);
        chk(!req16 && !req8, "R6 idle when full", 32'({req16, req8}), 32'h0);
        chk(acc16 - s16 == 3, "R5 word accesses", 32'(acc16 - s16), 32'd3);
        chk(acc8 - s8 == 6, "R4 byte accesses", 32'(acc8 - s8), 32'd6);
        consume(16'h3000, 16'h0100, 6, "R1 full drain");

        // R6/R5: odd start on the word bus stops at five bytes
        do_flush(16'h3000, 16'h0101);
        @(negedge clk);
        chk(req16 && !wide16 && addr16 == 20'h30101, "R5 odd first narrow", 32'({wide16, addr16}), 32'h30101);
        repeat (40) @(negedge clk);
        chk(q16_cnt == 3'd5, "R6 odd fill bus16", 32'(q16_cnt), 32'd5);
        chk(q8_cnt == 3'd6, "R6 odd fill bus8", 32'(q8_cnt), 32'd6);
        consume(16'h3000, 16'h0101, 8, "R5 odd stream");

        // R8: take on an empty queue is ignored
        stall = 1'b1;
        do_flush(16'h4000, 16'h0020);
        take16 = 1'b1; take8 = 1'b1;
        repeat (6) @(negedge clk);
        chk(q16_empty && q8_empty, "R8 stays empty", 32'({q16_empty, q8_empty}), 32'h3);
        chk(req16 && req8, "R11 request held while stalled", 32'({req16, req8}), 32'h3);
        chk(addr16 == 20'h40020, "R11 address steady", 32'(addr16), 32'h40020);
        take16 = 1'b0; take8 = 1'b0; stall = 1'b0;
        consume(16'h4000, 16'h0020, 4, "R8 first byte kept");

        // R7: flush during a pending access
        lat = 4;
        do_flush(16'h5000, 16'h0000);
        repeat (3) @(negedge clk);
        chk(req16 && addr16 == 20'h50000, "R11 pending access", 32'(addr16), 32'h50000);
        do_flush(16'h6000, 16'h0010);
        chk(q16_empty && q8_empty && q16_cnt == 0 && q8_cnt == 0, "R7 flush empties",
            32'({q16_cnt, q8_cnt}), 32'h0);
        chk(!req16 && !req8, "R7 request dropped", 32'({req16, req8}), 32'h0);
        consume(16'h6000, 16'h0010, 6, "R7 restart data");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule